// File: doc/BRIEF.md
# System Controller Register Bank

This block is the bus-facing register window of a small system controller. It sits on a 32-bit word-addressed bus with sixteen word slots. It holds GPIO output and interrupt-enable registers, a synchronised GPIO input register, a read-only capabilities word, a system identification word and a reconfiguration-port register.

Two kinds of bus write are commands, not stores. A write to the identification slot asks for a system reset. A write of the shutdown code to the reconfiguration slot asks for a shutdown. Each request leaves the block as a one-cycle pulse.

The six timer slots are not stored here. They are passed through to two external timer instances over a select-and-data interface in the same cycle, and reads of those slots return the selected timer's data in that cycle. Accesses to the unused slots are absorbed and recorded in a sticky debug flag.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word index 0 (GPIO input) reads the strap value (default 0x00000001), index 1 (GPIO output) and index 2 (interrupt enable) read 0, index 13 (reconfiguration) reads 0x00000001 (bit 0 = ready), index 14 (capabilities) reads the configured value (default 0), and index 15 (identification) reads the configured value (default 0x10014D31).
- R2: Writes to index 1 and index 2 store the low GPIO_W bits. These bits drive `gpio_out` and `gpio_irq_en` from the cycle after the write. They read back zero-extended.
- R3: Writes to index 0 and index 14 leave their read values unchanged.
- R4: A write to index 13 whose bits [15:0] equal 0x000E raises `shutdown_req` in the cycle after the write is accepted, whatever bits [31:16] hold. Any other value of bits [15:0] raises no request, and the register still reads 0x00000001.
- R5: Any write to index 15 raises `reset_req` in the cycle after the write is accepted, whatever the data. The identification value is unchanged.
- R6: Each request pulse lasts exactly one cycle per accepted write, and no request is raised by reads or by accesses to other slots.
- R7: Indices 3, 7, 11 and 12 are reserved. They read 0, writes to them are discarded, and any access sets `bad_access`, which stays set until reset.
- R8: Indices 4/5/6 map to timer unit 0 and indices 8/9/10 map to timer unit 1, with slot 0 = control, 1 = compare and 2 = counter. An access drives `tmr_valid`, `tmr_unit`, `tmr_slot`, `tmr_we` and `tmr_wdata` in the same cycle, and a read returns that unit's `tmr_rdata` in the same cycle.
- R9: The GPIO input register tracks `gpio_pins` through two flops. A pin change becomes visible on a read after the second rising edge that follows it.
- R10: Accesses to non-reserved slots never set `bad_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| gpio_pins | input | GPIO_W | Asynchronous GPIO inputs |
| gpio_out | output | GPIO_W | GPIO output register |
| gpio_irq_en | output | GPIO_W | GPIO interrupt-enable register |
| tmr_valid | output | 1 | Timer slot access strobe |
| tmr_we | output | 1 | Timer slot write |
| tmr_unit | output | 1 | Selected timer instance |
| tmr_slot | output | 2 | 0 control, 1 compare, 2 counter |
| tmr_wdata | output | 32 | Timer write data |
| tmr_rdata0 | input | 32 | Read data of timer unit 0 |
| tmr_rdata1 | input | 32 | Read data of timer unit 1 |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |
| bad_access | output | 1 | Sticky reserved-slot access flag |

## Verification
Read data and the timer forwarding signals are combinational, so they are due in the same cycle as the access. The bench drives each access after a falling edge and samples these results one time step later, before the rising edge. Request pulses, stored GPIO values and `bad_access` are due in the cycle after the accepting edge, so they are sampled at the next falling edge, and the pulse is checked low again one falling edge later. Pin changes go through the two-flop path, so the bench reads once after the first edge, expecting the old value, and again after the second, expecting the new one.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] IDX_GPIN  = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_GPOUT = 4'd1;
    localparam logic [ADDR_W-1:0] IDX_GPIEN = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_RECFG = 4'd13;
    localparam logic [ADDR_W-1:0] IDX_CAPS  = 4'd14;
    localparam logic [ADDR_W-1:0] IDX_SYSID = 4'd15;

    localparam logic [15:0] SHUTDOWN_CODE = 16'h000E;
    localparam logic [DATA_W-1:0] RECFG_READY = 32'h0000_0001;

    typedef struct packed {
        logic is_gpin;
        logic is_gpout;
        logic is_gpien;
        logic is_recfg;
        logic is_caps;
        logic is_sysid;
        logic is_timer;
        logic is_rsvd;
        logic unit;
        logic [1:0] slot;
    } slot_dec_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output slot_dec_t         dec
);
    always_comb begin
        dec = '0;
        dec.unit = addr[3];
        dec.slot = addr[1:0];
        unique case (addr)
            IDX_GPIN:  dec.is_gpin  = 1'b1;
            IDX_GPOUT: dec.is_gpout = 1'b1;
            IDX_GPIEN: dec.is_gpien = 1'b1;
            IDX_RECFG: dec.is_recfg = 1'b1;
            IDX_CAPS:  dec.is_caps  = 1'b1;
            IDX_SYSID: dec.is_sysid = 1'b1;
            4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10: dec.is_timer = 1'b1;
            default:   dec.is_rsvd  = 1'b1;
        endcase
    end
endmodule

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] sync_q, sync_d;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned GPIO_W = 8,
    parameter logic [DATA_W-1:0] SYS_ID = 32'h1001_4D31,
    parameter logic [DATA_W-1:0] CAPS   = 32'h0000_0000,
    parameter logic [GPIO_W-1:0] STRAP  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] gpio_pins,
    output logic [GPIO_W-1:0] gpio_out,
    output logic [GPIO_W-1:0] gpio_irq_en,
    output logic              tmr_valid,
    output logic              tmr_we,
    output logic              tmr_unit,
    output logic [1:0]        tmr_slot,
    output logic [DATA_W-1:0] tmr_wdata,
    input  logic [DATA_W-1:0] tmr_rdata0,
    input  logic [DATA_W-1:0] tmr_rdata1,
    output logic              shutdown_req,
    output logic              reset_req,
    output logic              bad_access
);
    localparam int unsigned PAD_W = DATA_W - GPIO_W;

    typedef struct packed {
        logic [GPIO_W-1:0] gpout;
        logic [GPIO_W-1:0] gpien;
        logic              shut;
        logic              sysrst;
        logic              err;
    } state_t;

    state_t    st_q, st_d;
    slot_dec_t dec;
    logic [GPIO_W-1:0] gpin_sync;
    logic wr, rd_any;

    sysctl_decode u_dec (.addr(bus_addr), .dec(dec));

    sysctl_sync #(.WIDTH(GPIO_W), .INIT(STRAP)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(gpio_pins), .dout(gpin_sync)
    );

    assign wr     = bus_valid && bus_we;
    assign rd_any = bus_valid;

    always_comb begin
        st_d        = st_q;
        st_d.shut   = 1'b0;
        st_d.sysrst = 1'b0;
        if (wr && dec.is_gpout) st_d.gpout = bus_wdata[GPIO_W-1:0];
        if (wr && dec.is_gpien) st_d.gpien = bus_wdata[GPIO_W-1:0];
        if (wr && dec.is_recfg && bus_wdata[15:0] == SHUTDOWN_CODE) st_d.shut = 1'b1;
        if (wr && dec.is_sysid) st_d.sysrst = 1'b1;
        if (rd_any && dec.is_rsvd) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.is_gpin)  bus_rdata = {{PAD_W{1'b0}}, gpin_sync};
        if (dec.is_gpout) bus_rdata = {{PAD_W{1'b0}}, st_q.gpout};
        if (dec.is_gpien) bus_rdata = {{PAD_W{1'b0}}, st_q.gpien};
        if (dec.is_recfg) bus_rdata = RECFG_READY;
        if (dec.is_caps)  bus_rdata = CAPS;
        if (dec.is_sysid) bus_rdata = SYS_ID;
        if (dec.is_timer) bus_rdata = dec.unit ? tmr_rdata1 : tmr_rdata0;
    end

    assign tmr_valid    = bus_valid && dec.is_timer;
    assign tmr_we       = bus_we;
    assign tmr_unit     = dec.unit;
    assign tmr_slot     = dec.slot;
    assign tmr_wdata    = bus_wdata;
    assign gpio_out     = st_q.gpout;
    assign gpio_irq_en  = st_q.gpien;
    assign shutdown_req = st_q.shut;
    assign reset_req    = st_q.sysrst;
    assign bad_access   = st_q.err;

    a_r4_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(bus_valid && bus_we && bus_addr == IDX_RECFG
                               && bus_wdata[15:0] == SHUTDOWN_CODE));
    a_r5_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(bus_valid && bus_we && bus_addr == IDX_SYSID));
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> bad_access);
    a_r8_timer_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_valid |-> bus_valid && !(bus_addr == IDX_SYSID || bus_addr == IDX_RECFG));
    a_r2_gpout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_we) |=> $stable(gpio_out) && $stable(gpio_irq_en));
endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0] gpio_pins = 8'h01;
    logic [7:0] gpio_out, gpio_irq_en;
    logic tmr_valid, tmr_we, tmr_unit;
    logic [1:0] tmr_slot;
    logic [31:0] tmr_wdata;
    logic [31:0] tmr_rdata0 = 32'hA0A0_0000, tmr_rdata1 = 32'hB1B1_0000;
    logic shutdown_req, reset_req, bad_access;
    int total = 0, bad = 0;
    logic [7:0] pin_mirror = 8'h01;

    always #5 clk = ~clk;

    sysctl_regbank u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic is_rsvd(input int a);
        return a == 3 || a == 7 || a == 11 || a == 12;
    endfunction

    function automatic logic is_tmr(input int a);
        return (a >= 4 && a <= 6) || (a >= 8 && a <= 10);
    endfunction

    function automatic logic [31:0] exp_read(input int a, input logic [7:0] go, input logic [7:0] ge);
        case (a)
            0: return {24'h0, pin_mirror};
            1: return {24'h0, go};
            2: return {24'h0, ge};
            13: return 32'h1;
            14: return 32'h0;
            15: return 32'h1001_4D31;
            default: begin
                if (is_tmr(a)) return (a >= 8) ? tmr_rdata1 : tmr_rdata0;
                return 32'h0;
            end
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at negedge, sample combinational read before posedge, then return at next negedge
    task automatic access(input logic we, input int a, input logic [31:0] d, output logic [31:0] rd);
        bus_valid = 1'b1; bus_we = we; bus_addr = 4'(a); bus_wdata = d;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        int unsigned cyc = 0;
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        bad++; total++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0] go, ge;
        do_reset();
        // R1: reset values across the whole window
        chk("R7 flag after reset", {31'h0, bad_access}, 0);
        for (int a = 0; a < 16; a++) begin
            if (is_rsvd(a)) continue;
            access(1'b0, a, 0, rd);
            chk($sformatf("R1 read idx %0d", a), rd, exp_read(a, 8'h0, 8'h0));
        end
        chk("R10 no flag on normal reads", {31'h0, bad_access}, 0);
        chk("R1 gpio_out reset", {24'h0, gpio_out}, 0);

        // R2: GPIO output and enable sweep
        go = 0; ge = 0;
        for (int v = 0; v < 256; v += 37) begin
            access(1'b1, 1, 32'hFFFF_FF00 | v, rd);
            go = 8'(v);
            chk("R2 gpio_out pin", {24'h0, gpio_out}, {24'h0, go});
            access(1'b1, 2, ~32'(v), rd);
            ge = ~8'(v);
            chk("R2 gpio_irq_en pin", {24'h0, gpio_irq_en}, {24'h0, ge});
            access(1'b0, 1, 0, rd);
            chk("R2 gpio_out readback", rd, {24'h0, go});
            access(1'b0, 2, 0, rd);
            chk("R2 enable readback", rd, {24'h0, ge});
        end

        // R3: read-only slots
        access(1'b1, 0, 32'hFFFF_FFFF, rd);
        access(1'b0, 0, 0, rd);
        chk("R3 gpio in unchanged", rd, 32'h1);
        access(1'b1, 14, 32'h1234_5678, rd);
        access(1'b0, 14, 0, rd);
        chk("R3 caps unchanged", rd, 32'h0);

        // R4/R6: reconfiguration commands; pulse sampled at the negedge after acceptance
        for (int k = 0; k < 8; k++) begin
            logic [31:0] d;
            logic hit;
            d = (k < 3) ? {16'(k * 16'h1357), 16'h000E} : {16'hDEAD, 16'(k * 3 + 16'h000F)};
            hit = (d[15:0] == 16'h000E);
            access(1'b1, 13, d, rd);
            chk("R4 shutdown pulse", {31'h0, shutdown_req}, {31'h0, hit});
            chk("R6 no reset on recfg", {31'h0, reset_req}, 0);
            @(negedge clk);
            chk("R6 shutdown one cycle", {31'h0, shutdown_req}, 0);
            access(1'b0, 13, 0, rd);
            chk("R4 recfg reads ready", rd, 32'h1);
        end
        // R6: back-to-back commands give one pulse per write
        access(1'b1, 13, 32'h000E, rd);
        access(1'b1, 13, 32'h000E, rd);
        chk("R6 second pulse", {31'h0, shutdown_req}, 1);
        @(negedge clk);
        chk("R6 pulses end", {31'h0, shutdown_req}, 0);
        access(1'b0, 13, 32'h000E, rd);
        chk("R6 read no pulse", {31'h0, shutdown_req}, 0);

        // R5: identification writes
        for (int k = 0; k < 3; k++) begin
            access(1'b1, 15, 32'(k) * 32'h5555_5555, rd);
            chk("R5 reset pulse", {31'h0, reset_req}, 1);
            chk("R6 no shutdown on id", {31'h0, shutdown_req}, 0);
            @(negedge clk);
            chk("R6 reset one cycle", {31'h0, reset_req}, 0);
            access(1'b0, 15, 0, rd);
            chk("R5 id unchanged", rd, 32'h1001_4D31);
        end

        // R8: timer forwarding on all six slots
        for (int a = 0; a < 16; a++) begin
            if (!is_tmr(a)) continue;
            bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 32'hC0DE_0000 | a;
            #1;
            chk("R8 tmr_valid", {31'h0, tmr_valid}, 1);
            chk("R8 tmr_unit", {31'h0, tmr_unit}, {31'h0, a >= 8});
            chk("R8 tmr_slot", {30'h0, tmr_slot}, 32'(a % 4));
            chk("R8 tmr_we", {31'h0, tmr_we}, 1);
            chk("R8 tmr_wdata", tmr_wdata, 32'hC0DE_0000 | a);
            @(negedge clk);
            bus_valid = 1'b0;
            tmr_rdata0 = 32'hA0A0_0000 | a; tmr_rdata1 = 32'hB1B1_0000 | a;
            access(1'b0, a, 0, rd);
            chk("R8 tmr read", rd, exp_read(a, go, ge));
        end
        bus_addr = 4'd4; #1;
        chk("R8 no strobe when idle", {31'h0, tmr_valid}, 0);
        chk("R10 flag still clear", {31'h0, bad_access}, 0);

        // R9: synchroniser latency
        @(negedge clk);
        gpio_pins = 8'h5A;
        @(negedge clk);
        access(1'b0, 0, 0, rd);
        chk("R9 old value after one edge", rd, 32'h1);
        pin_mirror = 8'h5A;
        access(1'b0, 0, 0, rd);
        chk("R9 new value after two edges", rd, 32'h5A);

        // R7: reserved slots
        for (int a = 0; a < 16; a++) begin
            if (!is_rsvd(a)) continue;
            access(1'b1, a, 32'hFFFF_FFFF, rd);
            chk("R7 flag set", {31'h0, bad_access}, 1);
            access(1'b0, a, 0, rd);
            chk("R7 reserved reads zero", rd, 0);
        end
        access(1'b0, 1, 0, rd);
        chk("R7 flag sticky", {31'h0, bad_access}, 1);
        chk("R7 writes discarded gpio_out", rd, {24'h0, go});
        do_reset();
        chk("R7 flag cleared by reset", {31'h0, bad_access}, 0);
        access(1'b0, 7, 0, rd);
        chk("R7 read sets flag", {31'h0, bad_access}, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule